// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write-Once Configuration

The block is a watchdog peripheral for a system-on-chip. A 12-bit counter counts down by one on each slow tick enable. Firmware must restart it before it runs out, and the restart is accepted only late in the period. That is, the counter must already have fallen to or below a programmed window value. A restart that arrives too early counts as a fault, in the same way as running out. Either fault sets a status flag, can raise an interrupt, and can pulse a reset request to the whole system or to the processor alone.

All configuration lives in one mode word. The mode word can be written once after reset. Every later write is dropped, so runaway code cannot reprogram or disable the watchdog. Restart commands carry an 8-bit key, so a stray store cannot act as a restart. Counting can be paused while an idle or debug input is high, when the matching mode bit allows it. Registers are reached over a minimal select/write bus with a combinational read path.

Top module: `wd_window_timer`

## Requirements
- R1: Out of reset the mode word reads 0x3FFF2FFF, the status word reads 0, and the interrupt and both reset requests are low. Word addresses are: control 0, mode 1, status 2. The control word reads 0.
- R2: Only the first mode write after reset is stored. Later writes leave the readback unchanged until the next reset. The accepted write reloads the counter with its load field, mode bits 11:0. The window field is mode bits 27:16.
- R3: With load value L, an underflow occurs on the (L+1)-th enabled tick after a reload. That tick is the one that arrives while the counter is 0. The counter then reloads to L.
- R4: A control write with bits 31:24 equal to 0xA5 and bit 0 set is a restart. When the counter is at or below the window value, the restart reloads the counter and raises no fault.
- R5: A restart while the counter is above the window value sets the window-fault flag, status bit 1. It is treated as a fault, and it still reloads the counter.
- R6: A control write with any other key, or with bit 0 clear, has no effect on the counter or on the faults.
- R7: Status bit 0 flags underflow and status bit 1 flags a window fault. Both flags clear when the status word is read. A fault in the same cycle as the read wins over the clear.
- R8: The interrupt is high while mode bit 12 is set and any status flag is set.
- R9: On a fault with mode bit 13 set, a one-cycle reset request follows in the next cycle. The processor-only request is used when mode bit 14 is set, and the system request otherwise. With bit 13 clear, neither request is raised.
- R10: While mode bit 29 is set and the idle input is high, ticks are ignored. The same holds for mode bit 28 and the debug input. An input whose halt bit is clear does not pause counting.
- R11: While mode bit 15 is set, the counter holds, restarts are ignored and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle count enable from the slow time base |
| idle_in | input | 1 | Processor idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 control, 1 mode, 2 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| fault_irq | output | 1 | Fault interrupt, level |
| sys_rst_req | output | 1 | System reset request, one-cycle pulse |
| cpu_rst_req | output | 1 | Processor-only reset request, one-cycle pulse |

## Verification
A corrupted counter cannot be read directly. It shows up at the ports as an underflow pulse on the wrong tick, or as a restart that is judged against the window wrongly. The bench therefore counts ticks up to the first request, and a counter that is off by one shows on the first period measured. It also sweeps the restart point over every counter value of a 16-tick period. A lock flag that is wrong shows at once in the mode readback after a second write. Flags that are stuck or fail to clear show in the next status read and in the level of the interrupt.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CNT_W         = 12;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 2;
  localparam int WIN_LSB       = 16;
  localparam int BIT_INT_EN    = 12;
  localparam int BIT_RST_EN    = 13;
  localparam int BIT_CPU_ONLY  = 14;
  localparam int BIT_DIS       = 15;
  localparam int BIT_DBG_HALT  = 28;
  localparam int BIT_IDLE_HALT = 29;
  localparam int KEY_W         = 8;
  localparam int KEY_LSB       = DATA_W - KEY_W;
  localparam int BIT_RESTART   = 0;
  localparam int N_FLAGS       = 2;
  localparam int FLAG_UFL      = 0;
  localparam int FLAG_WIN      = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] win;
    logic             int_en;
    logic             rst_en;
    logic             cpu_only;
    logic             dis;
    logic             idle_halt;
    logic             dbg_halt;
  } mode_t;

  function automatic mode_t decode_mode(input logic [DATA_W-1:0] w);
    mode_t m;
    m.load      = w[CNT_W-1:0];
    m.win       = w[WIN_LSB +: CNT_W];
    m.int_en    = w[BIT_INT_EN];
    m.rst_en    = w[BIT_RST_EN];
    m.cpu_only  = w[BIT_CPU_ONLY];
    m.dis       = w[BIT_DIS];
    m.idle_halt = w[BIT_IDLE_HALT];
    m.dbg_halt  = w[BIT_DBG_HALT];
    return m;
  endfunction
endpackage

// File: rtl/wdw_rst_sync.sv
module wdw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdw_mode_reg.sv
module wdw_mode_reg
  import wdw_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = 32'h3FFF_2FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_word,
  output logic              locked,
  output logic              accept
);
  logic [DATA_W-1:0] word_q, word_d;
  logic              lock_q, lock_d;

  always_comb begin
    accept = wr_en & ~lock_q;
    word_d = word_q;
    lock_d = lock_q;
    if (accept) begin
      word_d = wdata;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_VAL;
      lock_q <= 1'b0;
    end else begin
      word_q <= word_d;
      lock_q <= lock_d;
    end
  end

  assign mode_word = word_q;
  assign locked    = lock_q;
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_accept,
  input  logic [CNT_W-1:0] cfg_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] win_val,
  input  logic             disabled,
  input  logic             halted,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             ufl_ev,
  output logic             win_ev
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    ufl_ev = 1'b0;
    win_ev = 1'b0;
    if (cfg_accept) begin
      cnt_d = cfg_load;
    end else if (!disabled) begin
      if (restart) begin
        cnt_d  = load_val;
        win_ev = (cnt_q > win_val);
      end else if (tick && !halted) begin
        if (cnt_zero) begin
          ufl_ev = 1'b1;
          cnt_d  = load_val;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdw_fault.sv
module wdw_fault
  import wdw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ufl_ev,
  input  logic               win_ev,
  input  logic               stat_rd,
  input  logic               int_en,
  input  logic               rst_en,
  input  logic               cpu_only,
  output logic [N_FLAGS-1:0] flags,
  output logic               irq,
  output logic               sys_req,
  output logic               cpu_req
);
  logic [N_FLAGS-1:0] ev_vec;
  logic [N_FLAGS-1:0] flag_q, flag_d;
  logic               sys_q, sys_d, cpu_q, cpu_d, any_ev;

  always_comb begin
    ev_vec           = '0;
    ev_vec[FLAG_UFL] = ufl_ev;
    ev_vec[FLAG_WIN] = win_ev;
    any_ev           = |ev_vec;
    sys_d            = any_ev & rst_en & ~cpu_only;
    cpu_d            = any_ev & rst_en &  cpu_only;
  end

  genvar g;
  generate
    for (g = 0; g < N_FLAGS; g++) begin : g_flag
      always_comb begin
        if (ev_vec[g])    flag_d[g] = 1'b1;
        else if (stat_rd) flag_d[g] = 1'b0;
        else              flag_d[g] = flag_q[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      sys_q  <= 1'b0;
      cpu_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      sys_q  <= sys_d;
      cpu_q  <= cpu_d;
    end
  end

  assign flags   = flag_q;
  assign irq     = int_en & (|flag_q);
  assign sys_req = sys_q;
  assign cpu_req = cpu_q;
endmodule

// File: rtl/wd_window_timer.sv
module wd_window_timer
  import wdw_pkg::*;
#(
  parameter logic [DATA_W-1:0] MODE_RST = 32'h3FFF_2FFF,
  parameter logic [KEY_W-1:0]  KEY_VAL  = 8'hA5,
  parameter int                SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              idle_in,
  input  logic              dbg_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fault_irq,
  output logic              sys_rst_req,
  output logic              cpu_rst_req
);
  localparam logic [CNT_W-1:0] CNT_RST = MODE_RST[CNT_W-1:0];

  logic               rst_sync_n;
  logic               wr_mode, wr_ctrl, rd_stat, restart, halted;
  logic [DATA_W-1:0]  mode_q;
  logic               locked, cfg_accept;
  mode_t              mode;
  logic [CNT_W-1:0]   cnt_q;
  logic               ufl_ev, win_ev;
  logic [N_FLAGS-1:0] flags;

  wdw_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_mode = bus_sel &  bus_wr & (bus_addr == REG_MODE);
    wr_ctrl = bus_sel &  bus_wr & (bus_addr == REG_CTRL);
    rd_stat = bus_sel & ~bus_wr & (bus_addr == REG_STAT);
    restart = wr_ctrl & (bus_wdata[KEY_LSB +: KEY_W] == KEY_VAL)
                      & bus_wdata[BIT_RESTART];
  end

  wdw_mode_reg #(.RST_VAL(MODE_RST)) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_mode),
    .wdata     (bus_wdata),
    .mode_word (mode_q),
    .locked    (locked),
    .accept    (cfg_accept)
  );

  always_comb begin
    mode   = decode_mode(mode_q);
    halted = (mode.idle_halt & idle_in) | (mode.dbg_halt & dbg_in);
  end

  wdw_counter #(.CNT_RST(CNT_RST)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_accept (cfg_accept),
    .cfg_load   (bus_wdata[CNT_W-1:0]),
    .load_val   (mode.load),
    .win_val    (mode.win),
    .disabled   (mode.dis),
    .halted     (halted),
    .tick       (tick_en),
    .restart    (restart),
    .cnt        (cnt_q),
    .ufl_ev     (ufl_ev),
    .win_ev     (win_ev)
  );

  wdw_fault u_flt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ufl_ev   (ufl_ev),
    .win_ev   (win_ev),
    .stat_rd  (rd_stat),
    .int_en   (mode.int_en),
    .rst_en   (mode.rst_en),
    .cpu_only (mode.cpu_only),
    .flags    (flags),
    .irq      (fault_irq),
    .sys_req  (sys_rst_req),
    .cpu_req  (cpu_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_MODE: bus_rdata = mode_q;
      REG_STAT: bus_rdata[N_FLAGS-1:0] = flags;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wd_window_timer_chk.sv
module wd_window_timer_chk
  import wdw_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic [DATA_W-1:0] mode_q,
  input logic              locked,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              idle_in,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              fault_irq,
  input logic              sys_rst_req,
  input logic              cpu_rst_req
);
  // R2: once locked, the mode word never changes
  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> $stable(mode_q));

  // R3: after the lock the counter never exceeds its load value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |-> (cnt_q <= mode_q[CNT_W-1:0]));

  // R9: the two reset requests are never raised together
  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sys_rst_req && cpu_rst_req));

  // R9: a reset request needs the reset enable in the previous cycle
  p_req_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sys_rst_req || cpu_rst_req) |-> $past(mode_q[BIT_RST_EN]));

  // R8: a masked interrupt stays low
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_q[BIT_INT_EN] |-> !fault_irq);

  // R10: the idle halt freezes the counter when no write arrives
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && mode_q[BIT_IDLE_HALT] && idle_in && !(bus_sel && bus_wr)) |=> $stable(cnt_q));

  // R11: a locked disable freezes the counter and silences requests
  p_dis_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && mode_q[BIT_DIS]) |=> $stable(cnt_q));

  p_dis_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && mode_q[BIT_DIS]) |=> !(sys_rst_req || cpu_rst_req));
endmodule

bind wd_window_timer wd_window_timer_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .mode_q      (mode_q),
  .locked      (locked),
  .cnt_q       (cnt_q),
  .idle_in     (idle_in),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .fault_irq   (fault_irq),
  .sys_rst_req (sys_rst_req),
  .cpu_rst_req (cpu_rst_req)
);

// File: tb/wd_window_timer_tb.sv
module wd_window_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, idle_in = 1'b0, dbg_in = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_irq, sys_rst_req, cpu_rst_req;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  last_sys, last_cpu, saw_req;

  always #5 clk = ~clk;

  wd_window_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idle_in(idle_in), .dbg_in(dbg_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_irq(fault_irq), .sys_rst_req(sys_rst_req),
    .cpu_rst_req(cpu_rst_req)
  );

  localparam logic [1:0] A_CTRL = 2'd0, A_MODE = 2'd1, A_STAT = 2'd2;
  localparam logic [31:0] RESTART = 32'hA500_0001;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idle_in = 1'b0; dbg_in = 1'b0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    last_sys = sys_rst_req; last_cpu = cpu_rst_req;
    if (sys_rst_req || cpu_rst_req) saw_req = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    last_sys = sys_rst_req; last_cpu = cpu_rst_req;
    if (sys_rst_req || cpu_rst_req) saw_req = 1'b1;
  endtask

  // ticks until the first reset request (use_irq = 0) or interrupt (use_irq = 1)
  task automatic run_until(input int limit, input bit use_irq, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      tick_once();
      if (use_irq ? fault_irq : (last_sys || last_cpu)) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    bit exp_flt;
    int loads[4] = '{0, 1, 2, 7};

    // R1 reset state
    do_reset();
    bus_read(A_MODE, d);  chk(d == 32'h3FFF_2FFF, "R1 mode", d, 32'h3FFF_2FFF);
    bus_read(A_STAT, d);  chk(d == 0, "R1 status", d, 0);
    bus_read(A_CTRL, d);  chk(d == 0, "R1 control", d, 0);
    chk({fault_irq, sys_rst_req, cpu_rst_req} == 3'b000, "R1 outputs",
        {fault_irq, sys_rst_req, cpu_rst_req}, 0);

    // R3 default period 0xFFF+1, system request (R9), status then read-clear (R7)
    run_until(5000, 1'b0, n);
    chk(n == 4096, "R3 default period", n, 4096);
    chk(last_sys && !last_cpu, "R9 default system request", {last_sys, last_cpu}, 2'b10);
    chk(!fault_irq, "R8 masked irq", fault_irq, 0);
    bus_read(A_STAT, d);  chk(d == 1, "R7 underflow flag", d, 1);
    bus_read(A_STAT, d);  chk(d == 0, "R7 read clear", d, 0);

    // R2 write once: load 15, window 5, irq+reset enable
    do_reset();
    bus_write(A_MODE, 32'h0005_300F);
    bus_read(A_MODE, d);  chk(d == 32'h0005_300F, "R2 first write", d, 32'h0005_300F);
    bus_write(A_MODE, 32'h0000_2003);
    bus_read(A_MODE, d);  chk(d == 32'h0005_300F, "R2 second write ignored", d, 32'h0005_300F);

    // R4/R5 sweep restart position across the whole period
    for (int k = 0; k <= 15; k++) begin
      repeat (k) tick_once();
      bus_write(A_CTRL, RESTART);
      exp_flt = ((15 - k) > 5);
      chk(last_sys == exp_flt, exp_flt ? "R5 early restart request" : "R4 legal restart quiet",
          last_sys, exp_flt);
      chk(fault_irq == exp_flt, "R8 irq follows flag", fault_irq, exp_flt);
      bus_read(A_STAT, d);
      chk(d == (exp_flt ? 2 : 0), exp_flt ? "R5 window flag" : "R4 no flag", d, exp_flt ? 2 : 0);
      chk(!fault_irq, "R7 irq after read clear", fault_irq, 0);
    end

    // R3 full period after restart reload
    run_until(40, 1'b0, n);
    chk(n == 16, "R3 period after restart", n, 16);
    bus_read(A_STAT, d);  chk(d == 1, "R7 underflow only", d, 1);

    // R6 bad key / missing restart bit do nothing
    repeat (3) tick_once();
    bus_write(A_CTRL, 32'h5A00_0001);
    chk(!last_sys, "R6 wrong key", last_sys, 0);
    bus_write(A_CTRL, 32'hA500_0000);
    chk(!last_sys, "R6 restart bit clear", last_sys, 0);
    run_until(40, 1'b0, n);
    chk(n == 13, "R6 counter not reloaded", n, 13);
    bus_read(A_STAT, d);  chk(d == 1, "R6 no window flag", d, 1);

    // R3/R9 load sweep with processor-only request
    for (int i = 0; i < 4; i++) begin
      do_reset();
      d = loads[i] | (loads[i] << 16) | 32'h6000;
      bus_write(A_MODE, d);
      run_until(20, 1'b0, n);
      chk(n == loads[i] + 1, "R3 load sweep period", n, loads[i] + 1);
      chk(last_cpu && !last_sys, "R9 processor-only request", {last_sys, last_cpu}, 2'b01);
      run_until(20, 1'b0, n);
      chk(n == loads[i] + 1, "R3 reload after underflow", n, loads[i] + 1);
    end

    // R10 idle halt enabled, debug halt disabled
    do_reset();
    bus_write(A_MODE, 32'h2007_2007);
    saw_req = 1'b0;
    idle_in = 1'b1;
    repeat (12) tick_once();
    chk(!saw_req, "R10 idle halt pauses", saw_req, 0);
    idle_in = 1'b0; dbg_in = 1'b1;
    run_until(20, 1'b0, n);
    chk(n == 8, "R10 debug without halt bit counts", n, 8);
    dbg_in = 1'b0;

    // R10 debug halt enabled, idle halt disabled
    do_reset();
    bus_write(A_MODE, 32'h1007_2007);
    saw_req = 1'b0;
    dbg_in = 1'b1;
    repeat (12) tick_once();
    chk(!saw_req, "R10 debug halt pauses", saw_req, 0);
    dbg_in = 1'b0; idle_in = 1'b1;
    run_until(20, 1'b0, n);
    chk(n == 8, "R10 idle without halt bit counts", n, 8);
    idle_in = 1'b0;

    // R8/R9 interrupt only, no reset request
    do_reset();
    bus_write(A_MODE, 32'h0003_1003);
    saw_req = 1'b0;
    run_until(10, 1'b1, n);
    chk(n == 4, "R8 irq on underflow", n, 4);
    chk(!saw_req, "R9 no request without enable", saw_req, 0);
    bus_read(A_STAT, d);  chk(d == 1, "R7 flag with irq", d, 1);

    // R11 disable
    do_reset();
    bus_write(A_MODE, 32'h0000_B003);
    saw_req = 1'b0;
    repeat (20) tick_once();
    bus_write(A_CTRL, RESTART);
    chk(!saw_req, "R11 no request while disabled", saw_req, 0);
    chk(!fault_irq, "R11 no irq while disabled", fault_irq, 0);
    bus_read(A_STAT, d);  chk(d == 0, "R11 no flags while disabled", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule